// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the internal system clock and the serial-port clocks for an audio converter. A select bit picks either an external master clock or a phase-locked-loop clock as the source. That source then passes through a programmable divider. Its ratios are 1, 1.5, 2, 3, 4, 6, 8 and 12. The 1.5 ratio is built from both edges of the source. The divided system clock then feeds a second divider that makes the serial bit clock. A frame counter turns the bit clock into a frame clock of 64 bit-clock periods, high for the first half of each frame.

Software sets the block through a single 8-bit configuration word. In master mode the block drives its own bit clock and frame clock out, with output enables asserted. In slave mode the enables are low, and the external bit and frame clocks are handed straight to the serial-port logic. Divider changes are staged so that no runt pulse appears. A new system ratio starts at the end of the current system-clock period. A new bit-clock ratio starts at the next frame boundary.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the source is the PLL clock, the system ratio is 2, the bit-clock ratio is 1, the block is in slave mode (both output enables low), and the reserved flag is low.
- R2: Configuration bit 0 selects the source: 0 chooses `mclk`, 1 chooses `pll_clk`. The system clock period scales with the chosen source period.
- R3: Configuration bits 3:1 set the system ratio, with codes 0..7 meaning 1, 1.5, 2, 3, 4, 6, 8, 12. For the even ratios the high time is half the period. For ratio 3 the high time is one source period. For ratio 1 the system clock is the source itself.
- R4: For code 1 the system clock period is exactly 1.5 source periods on every cycle, with a high time of half a source period.
- R5: Configuration bits 6:4 set the bit-clock ratio relative to the system clock, with codes 0..5 meaning 1, 2, 4, 8, 16, 32. For ratios of 2 or more the high time is half the period.
- R6: In master mode the frame clock period is 64 bit-clock periods, and it is high for the first 32.
- R7: Writing bit-clock code 6 or 7 leaves the bit-clock ratio unchanged and sets `rsvd_flag`. The next write with a valid code clears the flag.
- R8: Configuration bit 7 selects master mode. When it is 0, `bclk_oe` and `frm_oe` are low and `port_bclk`/`port_frm` equal `bclk_in`/`frm_in`. When it is 1, both enables are high and the serial-port clocks come from the internal dividers.
- R9: A new system ratio takes effect only when the current system-clock period ends. A new bit-clock ratio takes effect only at a frame boundary, so the bit clock keeps its old period for the rest of the current frame.
- R10: Holding `rst_n` low at a source clock edge restores every field to its reset value and zeroes the counters. While reset is held, `sysclk` follows the selected source undivided.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | External master clock |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: [0] source, [3:1] system ratio, [6:4] bit-clock ratio, [7] master |
| sysclk | output | 1 | Divided internal system clock |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable (master mode) |
| frm_o | output | 1 | Generated frame clock |
| frm_oe | output | 1 | Frame clock output enable (master mode) |
| bclk_in | input | 1 | External bit clock used in slave mode |
| frm_in | input | 1 | External frame clock used in slave mode |
| port_bclk | output | 1 | Bit clock delivered to serial-port logic |
| port_frm | output | 1 | Frame clock delivered to serial-port logic |
| rsvd_flag | output | 1 | Last write carried a reserved bit-clock code |

## Verification
Every system ratio is swept on both sources. The two source periods are 20 ns and 15 ns, and they are chosen so that their edges never coincide. This shows that each ratio scales with the source and is not fixed in time. Two back-to-back periods are measured at ratio 1.5. This tells a true 1.5 ratio apart from a divider that alternates between one and two source cycles. All six bit-clock ratios are measured with their matching frame periods and high times. Ratio changes are issued mid-period and mid-frame, and the old period is shown to survive until its boundary. Reserved codes, slave pass-through and a reset from a non-default state each get their own stimulus.

// File: rtl/audio_clkgen.sv
`timescale 1ns/100ps
module audio_clkgen #(
  parameter int FRAME_LEN = 64
) (
  input  logic       mclk,
  input  logic       pll_clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       sysclk,
  output logic       bclk_o,
  output logic       bclk_oe,
  output logic       frm_o,
  output logic       frm_oe,
  input  logic       bclk_in,
  input  logic       frm_in,
  output logic       port_bclk,
  output logic       port_frm,
  output logic       rsvd_flag
);
  localparam int CW = $clog2(FRAME_LEN) + 5;
  localparam int IW = $clog2(CW);

  logic       cfg_src, cfg_master;
  logic [2:0] cfg_sys, cfg_bck;
  logic       src_clk;
  logic       bad_code;

  assign src_clk  = cfg_src ? pll_clk : mclk;
  assign bad_code = &cfg_wdata[6:5];

  always_ff @(posedge src_clk) begin
    if (!rst_n) begin
      cfg_src    <= 1'b1;
      cfg_sys    <= 3'd2;
      cfg_bck    <= 3'd0;
      cfg_master <= 1'b0;
      rsvd_flag  <= 1'b0;
    end else if (cfg_we) begin
      cfg_src    <= cfg_wdata[0];
      cfg_sys    <= cfg_wdata[3:1];
      cfg_master <= cfg_wdata[7];
      rsvd_flag  <= bad_code;
      if (!bad_code) cfg_bck <= cfg_wdata[6:4];
    end
  end

  // system divider: posedge counter plus a falling-edge copy for the 1.5 ratio
  logic [2:0] sys_act;
  logic [3:0] cnt, cnt_nx, span, half;
  logic [1:0] nq;
  logic       div_q, h15, wrap;

  always_comb begin
    case (sys_act)
      3'd0:    span = 4'd1;
      3'd1:    span = 4'd3;
      3'd2:    span = 4'd2;
      3'd3:    span = 4'd3;
      3'd4:    span = 4'd4;
      3'd5:    span = 4'd6;
      3'd6:    span = 4'd8;
      default: span = 4'd12;
    endcase
  end

  assign half   = span >> 1;
  assign wrap   = (cnt == span - 4'd1);
  assign cnt_nx = wrap ? 4'd0 : cnt + 4'd1;

  always_ff @(posedge src_clk) begin
    if (!rst_n) begin
      cnt     <= 4'd0;
      sys_act <= 3'd2;
      div_q   <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      div_q <= (cnt_nx < half);
      if (wrap) sys_act <= cfg_sys;
    end
  end

  always_ff @(negedge src_clk) begin
    if (!rst_n) nq <= 2'd0;
    else        nq <= cnt[1:0];
  end

  assign h15 = (cnt == 4'd0 && nq == 2'd2) || (cnt == 4'd1 && nq == 2'd1);

  assign sysclk = (!rst_n || sys_act == 3'd0) ? src_clk
                : (sys_act == 3'd1) ? h15 : div_q;

  // bit clock and frame counter in the system clock domain
  logic [2:0]    bck_act;
  logic [CW-1:0] fc, fc_nx, flast, fhalf;
  logic [IW-1:0] bidx;
  logic          bclk_q, frm_q, bbit, bclk_int;

  assign flast = CW'((FRAME_LEN << bck_act) - 1);
  assign fhalf = CW'((FRAME_LEN / 2) << bck_act);
  assign fc_nx = (fc == flast) ? '0 : fc + CW'(1);
  assign bidx  = IW'(bck_act) - IW'(1);
  assign bbit  = (bck_act == 3'd0) ? 1'b0 : fc_nx[bidx];

  always_ff @(posedge sysclk) begin
    if (!rst_n) begin
      fc      <= '0;
      bck_act <= 3'd0;
      bclk_q  <= 1'b0;
      frm_q   <= 1'b0;
    end else begin
      fc     <= fc_nx;
      bclk_q <= ~bbit;
      frm_q  <= (fc_nx < fhalf);
      if (fc == flast) bck_act <= cfg_bck;
    end
  end

  assign bclk_int  = (bck_act == 3'd0) ? sysclk : bclk_q;
  assign bclk_o    = bclk_int;
  assign frm_o     = frm_q;
  assign bclk_oe   = cfg_master;
  assign frm_oe    = cfg_master;
  assign port_bclk = cfg_master ? bclk_int : bclk_in;
  assign port_frm  = cfg_master ? frm_q : frm_in;
endmodule

module audio_clkgen_chk (
  input logic       src_clk,
  input logic       sysclk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic       rsvd_flag,
  input logic       bclk_oe,
  input logic       frm_oe,
  input logic       bclk_in,
  input logic       frm_in,
  input logic       port_bclk,
  input logic       port_frm,
  input logic [2:0] sys_act,
  input logic       cnt_zero,
  input logic [2:0] bck_act,
  input logic       fc_zero
);
  p_reset_clears_r10: assert property (@(posedge src_clk)
    !rst_n |=> (!bclk_oe && !frm_oe && !rsvd_flag));

  p_flag_set_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cfg_we && (&cfg_wdata[6:5])) |=> rsvd_flag);

  p_flag_clear_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cfg_we && !(&cfg_wdata[6:5])) |=> !rsvd_flag);

  p_slave_pass_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
    !bclk_oe |-> (port_bclk == bclk_in && port_frm == frm_in));

  p_sys_adopt_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(sys_act) |-> cnt_zero);

  p_bck_adopt_r9: assert property (@(posedge sysclk) disable iff (!rst_n)
    !$stable(bck_act) |-> fc_zero);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .src_clk(src_clk), .sysclk(sysclk), .rst_n(rst_n),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rsvd_flag(rsvd_flag),
  .bclk_oe(bclk_oe), .frm_oe(frm_oe), .bclk_in(bclk_in), .frm_in(frm_in),
  .port_bclk(port_bclk), .port_frm(port_frm),
  .sys_act(sys_act), .cnt_zero(cnt == 4'd0),
  .bck_act(bck_act), .fc_zero(fc == '0)
);

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/100ps
module audio_clkgen_bench;
  logic mclk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic bclk_in = 1'b0, frm_in = 1'b0;
  logic sysclk, bclk_o, bclk_oe, frm_o, frm_oe, port_bclk, port_frm, rsvd_flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic cur_src = 1'b0;

  audio_clkgen u_audio_clkgen (
    .mclk(mclk), .pll_clk(pll_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sysclk(sysclk), .bclk_o(bclk_o), .bclk_oe(bclk_oe), .frm_o(frm_o), .frm_oe(frm_oe),
    .bclk_in(bclk_in), .frm_in(frm_in), .port_bclk(port_bclk), .port_frm(port_frm),
    .rsvd_flag(rsvd_flag));

  always #10 mclk = ~mclk;
  initial begin #3; forever #7.5 pll_clk = ~pll_clk; end

  realtime s_last = 0, s_per = 0, s_hi = 0;
  realtime b_last = 0, b_per = 0, b_hi = 0;
  realtime f_last = 0, f_per = 0, f_hi = 0;
  always @(posedge sysclk)    begin s_per = $realtime - s_last; s_last = $realtime; end
  always @(negedge sysclk)    s_hi = $realtime - s_last;
  always @(posedge port_bclk) begin b_per = $realtime - b_last; b_last = $realtime; end
  always @(negedge port_bclk) b_hi = $realtime - b_last;
  always @(posedge port_frm)  begin f_per = $realtime - f_last; f_last = $realtime; end
  always @(negedge port_frm)  f_hi = $realtime - f_last;

  task automatic chk_t(input string req, input string what, input realtime act, input realtime exp);
    checks++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic src_edge();
    if (cur_src) @(posedge pll_clk); else @(posedge mclk);
  endtask

  task automatic wr(input logic [7:0] d);
    src_edge(); #1; cfg_we = 1'b1; cfg_wdata = d;
    src_edge(); #1; cfg_we = 1'b0;
    cur_src = d[0];
  endtask

  task automatic sys_rises(input int n); repeat (n) @(posedge sysclk);   #0.5; endtask
  task automatic bclk_rises(input int n); repeat (n) @(posedge port_bclk); #0.5; endtask
  task automatic frm_rises(input int n); repeat (n) @(posedge port_frm);  #0.5; endtask

  function automatic real ratio(input int code);
    case (code)
      0: return 1.0;  1: return 1.5;  2: return 2.0;  3: return 3.0;
      4: return 4.0;  5: return 6.0;  6: return 8.0;  default: return 12.0;
    endcase
  endfunction

  function automatic logic [7:0] word(input bit m, input int bck, input int sys, input bit s);
    return {m, 3'(bck), 3'(sys), s};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: during reset sysclk follows the source (PLL after the first edge)
    sys_rises(6);
    chk_t("R10", "sysclk period in reset", s_per, 15.0);
    @(posedge pll_clk); #1; rst_n = 1'b1; cur_src = 1'b1;
    #2;
    chk_b("R1", "bclk_oe", bclk_oe, 1'b0);
    chk_b("R1", "frm_oe", frm_oe, 1'b0);
    chk_b("R1", "rsvd_flag", rsvd_flag, 1'b0);
    sys_rises(4);
    chk_t("R1", "sysclk period (PLL/2)", s_per, 30.0);
    chk_t("R1", "sysclk high", s_hi, 15.0);

    // R8: slave pass-through
    bclk_in = 1'b1; frm_in = 1'b0; #2;
    chk_b("R8", "port_bclk follows input", port_bclk, 1'b1);
    chk_b("R8", "port_frm follows input", port_frm, 1'b0);
    bclk_in = 1'b0; frm_in = 1'b1; #2;
    chk_b("R8", "port_bclk follows input", port_bclk, 1'b0);
    chk_b("R8", "port_frm follows input", port_frm, 1'b1);
    frm_in = 1'b0;

    // R2, R3, R4: every system ratio on both sources
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        realtime t, p;
        t = (s == 1) ? 15.0 : 20.0;
        p = ratio(c) * t;
        wr(word(1'b0, 0, c, s[0]));
        sys_rises(4);
        chk_t(c == 1 ? "R4" : "R3", $sformatf("src%0d code%0d period", s, c), s_per, p);
        sys_rises(1);
        chk_t(c == 1 ? "R4" : "R2", $sformatf("src%0d code%0d period again", s, c), s_per, p);
        chk_t(c == 1 ? "R4" : "R3", $sformatf("src%0d code%0d high", s, c), s_hi,
              (c == 0 || c == 1) ? t / 2.0 : (c == 3) ? t : p / 2.0);
      end
    end

    // R5, R6, R8: master mode, sysclk = mclk/2 (40 ns)
    for (int k = 0; k < 6; k++) begin
      realtime bp;
      bp = 40.0 * real'(1 << k);
      wr(word(1'b1, k, 2, 1'b0));
      #2;
      chk_b("R8", "bclk_oe in master", bclk_oe, 1'b1);
      chk_b("R8", "frm_oe in master", frm_oe, 1'b1);
      frm_rises(2);
      chk_t("R6", $sformatf("frame period bck%0d", k), f_per, 64.0 * bp);
      chk_t("R6", $sformatf("frame high bck%0d", k), f_hi, 32.0 * bp);
      bclk_rises(2);
      chk_t("R5", $sformatf("bclk period bck%0d", k), b_per, bp);
      chk_t("R5", $sformatf("bclk high bck%0d", k), b_hi, bp / 2.0);
    end

    // R7: reserved codes ignored and flagged
    wr(word(1'b1, 2, 2, 1'b0));
    frm_rises(2);
    for (int r = 6; r < 8; r++) begin
      wr(word(1'b1, r, 2, 1'b0));
      #2;
      chk_b("R7", $sformatf("flag after code %0d", r), rsvd_flag, 1'b1);
      frm_rises(1); bclk_rises(2);
      chk_t("R7", $sformatf("bclk period kept after code %0d", r), b_per, 160.0);
    end
    wr(word(1'b1, 2, 2, 1'b0));
    #2;
    chk_b("R7", "flag cleared by valid write", rsvd_flag, 1'b0);

    // R9: bit-clock ratio change waits for frame boundary
    wr(word(1'b1, 1, 2, 1'b0));
    frm_rises(2);
    wr(word(1'b1, 3, 2, 1'b0));
    bclk_rises(2);
    chk_t("R9", "bclk keeps old period mid-frame", b_per, 80.0);
    frm_rises(1); bclk_rises(2);
    chk_t("R9", "bclk new period after frame", b_per, 320.0);

    // R9: system ratio change waits for end of period
    wr(word(1'b0, 0, 7, 1'b0));
    sys_rises(3);
    @(posedge sysclk);
    wr(word(1'b0, 0, 2, 1'b0));
    sys_rises(1);
    chk_t("R9", "sysclk completes old period", s_per, 240.0);
    sys_rises(2);
    chk_t("R9", "sysclk new period", s_per, 40.0);

    // R10: reset from a non-default state
    wr(word(1'b1, 7, 5, 1'b0));
    #2;
    chk_b("R10", "flag set before reset", rsvd_flag, 1'b1);
    @(posedge mclk); #1; rst_n = 1'b0;
    repeat (6) @(posedge mclk);
    #1;
    chk_b("R10", "bclk_oe after reset", bclk_oe, 1'b0);
    chk_b("R10", "rsvd_flag after reset", rsvd_flag, 1'b0);
    sys_rises(3);
    chk_t("R10", "sysclk undivided PLL in reset", s_per, 15.0);
    @(posedge pll_clk); #1; rst_n = 1'b1; cur_src = 1'b1;
    sys_rises(4);
    chk_t("R10", "sysclk PLL/2 after reset", s_per, 30.0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule